// File: doc/BRIEF.md
# Twin-Predicated Sub-Vector Loop Sequencer

This block steps one prefixed vector instruction over up to `vl` elements. Each element is a group of one to four sub-elements. For every sub-element it presents a source register number, a destination register number, the element index of each operand and the sub-element index to an execution unit, one step per cycle. Predication works on whole groups. The source and destination each have their own mask, taken from three fixed mask words that stand for scalar registers x9, x10 and x11. The two operand indices skip forward independently to their next enabled position.

The element offsets and the sub-element offset are kept in a 32-bit save word that is always visible on `state_out`. When an exception stops the loop, this word holds the exact point to continue from. Feeding the word back on `state_in` with the next `start` resumes the loop there, even in the middle of a sub-vector group.

The controller has four states. `ST_IDLE` waits for `start` and then moves to `ST_SEEK`. `ST_SEEK` finds the next enabled pair. If both operands find one, it moves to `ST_ISSUE`; if either runs out, it moves to `ST_FINISH`. `ST_ISSUE` presents one sub-element per cycle. It stays in `ST_ISSUE` inside a group. After the last sub-element it returns to `ST_SEEK`, or it goes to `ST_FINISH` when a predicated scalar ends the loop. `ST_FINISH` raises `done` for one cycle and returns to `ST_IDLE`. An `exception` seen in `ST_SEEK` or `ST_ISSUE` sends the controller straight back to `ST_IDLE`.

Top module: `svl_loop_seq`

## Requirements
- R1: The sub-vector code `svlen_code` gives n = code+1 sub-elements per element (00 gives plain elements). Each enabled element pair produces n consecutive steps with `issue_sub` counting 0 to n-1, one per cycle.
- R2: With `twin_mode`=0, `pred_code` picks one mask that applies to both operands. 000 and 001 mean no predication. 010/011 select x9, 100/101 select x10, 110/111 select x11. An odd code uses the mask as given; an even code uses its complement. A disabled element produces no step for any of its sub-elements.
- R3: With `twin_mode`=1, `pred_code` bit 0 applies x9 to the source and bit 1 applies x10 to the destination. Bit 2 complements whichever masks are applied. Codes 000 and 100 mean no predication.
- R4: The source and destination element indices each move to their own next enabled position. One group is issued per pair found, and both indices then advance by one. The loop ends when either index reaches the effective length.
- R5: A scalar operand's register number is its 6-bit field zero-extended and never changes. A vector operand's register number is {field[0], field[5:1], 0} plus its element index, modulo 128.
- R6: When a predicated operand is scalar, the loop ends after the first group it issues.
- R7: The effective length is `vl` clamped to MAX_VL. A length of zero produces `done` with no step. `done` is a single-cycle pulse after the last step.
- R8: An `exception` withdraws the step shown in that cycle (`issue_valid` low) and stops the loop. No further step follows, and the saved offsets point at the withdrawn step.
- R9: `state_out` holds maxvl in bits 5:0, the effective vl in 11:6, the source offset in 17:12, the destination offset in 23:18, n in 26:24, and the sub-element offset in 28:27 and 30:29. After completion the offsets are zero. After reset the word is 0x01000000 | MAX_VL.
- R10: On `start`, the source offset, destination offset and sub-element offset are loaded from the same bit positions of `state_in`. A word saved at an exception therefore resumes with the withdrawn step and continues the original sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a loop (honoured in idle) |
| exception | input | 1 | Abort the running loop and keep its offsets |
| vl | input | 6 | Requested vector length |
| svlen_code | input | 2 | Sub-elements per element minus one |
| twin_mode | input | 1 | 1: twin-predicate decoding of pred_code |
| pred_code | input | 3 | Predicate selection code |
| src_is_vec | input | 1 | Source operand is a vector |
| dst_is_vec | input | 1 | Destination operand is a vector |
| src_field | input | 6 | Source register field |
| dst_field | input | 6 | Destination register field |
| mask_x9 | input | MAX_VL | Mask word of x9 |
| mask_x10 | input | MAX_VL | Mask word of x10 |
| mask_x11 | input | MAX_VL | Mask word of x11 |
| state_in | input | 32 | Save word to resume from |
| issue_valid | output | 1 | A step is presented |
| issue_src_reg | output | 7 | Source register number |
| issue_dst_reg | output | 7 | Destination register number |
| issue_src_idx | output | 6 | Source element index |
| issue_dst_idx | output | 6 | Destination element index |
| issue_sub | output | 2 | Sub-element index |
| done | output | 1 | Loop complete pulse |
| state_out | output | 32 | Live save word |

## Verification
A `start` sampled at an edge puts the controller in `ST_SEEK` for the next cycle. The first step appears the cycle after that. Steps within a group follow one per cycle, and `ST_SEEK` adds one cycle between groups. `done` comes one cycle after the final step, or two cycles when the loop ends through `ST_SEEK`. The bench samples at falling edges and collects the whole step stream until `done`, so it checks order and content without depending on how the seek cycles are placed. The saved word is checked on the falling edge right after the exception edge. Three more falling edges then confirm that no step follows.

// File: rtl/svl_pkg.sv
package svl_pkg;
    localparam int VW = 6;
    localparam int RW = 7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEEK,
        ST_ISSUE,
        ST_FINISH
    } svl_state_e;

    typedef struct packed {
        logic           rsvd;
        logic [1:0]     dst_sub;
        logic [1:0]     src_sub;
        logic [2:0]     subvl;
        logic [VW-1:0]  dst_offs;
        logic [VW-1:0]  src_offs;
        logic [VW-1:0]  vlen;
        logic [VW-1:0]  maxvl;
    } svl_save_t;
endpackage

// File: rtl/svl_pred_sel.sv
module svl_pred_sel #(
    parameter int MAX_VL = 32
) (
    input  logic              twin,
    input  logic [2:0]        code,
    input  logic [MAX_VL-1:0] m9,
    input  logic [MAX_VL-1:0] m10,
    input  logic [MAX_VL-1:0] m11,
    output logic [MAX_VL-1:0] src_mask,
    output logic [MAX_VL-1:0] dst_mask,
    output logic              src_pred,
    output logic              dst_pred
);
    logic [MAX_VL-1:0] pick;

    always_comb begin
        src_mask = '1;
        dst_mask = '1;
        src_pred = 1'b0;
        dst_pred = 1'b0;
        pick     = '1;
        if (!twin) begin
            unique case (code[2:1])
                2'b01:   pick = m9;
                2'b10:   pick = m10;
                2'b11:   pick = m11;
                default: pick = '1;
            endcase
            if (code[2:1] != 2'b00) begin
                src_pred = 1'b1;
                dst_pred = 1'b1;
                src_mask = code[0] ? pick : ~pick;
                dst_mask = code[0] ? pick : ~pick;
            end
        end else if (code != 3'b100) begin
            if (code[0]) begin
                src_pred = 1'b1;
                src_mask = code[2] ? ~m9 : m9;
            end
            if (code[1]) begin
                dst_pred = 1'b1;
                dst_mask = code[2] ? ~m10 : m10;
            end
        end
    end
endmodule

// File: rtl/svl_find_next.sv
module svl_find_next
    import svl_pkg::*;
#(
    parameter int MAX_VL = 32
) (
    input  logic [MAX_VL-1:0] mask,
    input  logic [VW-1:0]     from,
    input  logic [VW-1:0]     lim,
    output logic              found,
    output logic [VW-1:0]     pos
);
    always_comb begin
        found = 1'b0;
        pos   = lim;
        for (int i = MAX_VL - 1; i >= 0; i--) begin
            if (VW'(i) >= from && VW'(i) < lim && mask[i]) begin
                found = 1'b1;
                pos   = VW'(i);
            end
        end
    end
endmodule

// File: rtl/svl_reg_map.sv
module svl_reg_map
    import svl_pkg::*;
(
    input  logic [5:0]    field,
    input  logic          is_vec,
    input  logic [VW-1:0] idx,
    output logic [RW-1:0] reg_num
);
    logic [RW-1:0] vbase;

    always_comb begin
        vbase   = {field[0], field[5:1], 1'b0};
        reg_num = is_vec ? (vbase + RW'(idx)) : {1'b0, field};
    end
endmodule

// File: rtl/svl_loop_seq.sv
module svl_loop_seq
    import svl_pkg::*;
#(
    parameter int MAX_VL = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              exception,
    input  logic [5:0]        vl,
    input  logic [1:0]        svlen_code,
    input  logic              twin_mode,
    input  logic [2:0]        pred_code,
    input  logic              src_is_vec,
    input  logic              dst_is_vec,
    input  logic [5:0]        src_field,
    input  logic [5:0]        dst_field,
    input  logic [MAX_VL-1:0] mask_x9,
    input  logic [MAX_VL-1:0] mask_x10,
    input  logic [MAX_VL-1:0] mask_x11,
    input  logic [31:0]       state_in,
    output logic              issue_valid,
    output logic [6:0]        issue_src_reg,
    output logic [6:0]        issue_dst_reg,
    output logic [5:0]        issue_src_idx,
    output logic [5:0]        issue_dst_idx,
    output logic [1:0]        issue_sub,
    output logic              done,
    output logic [31:0]       state_out
);
    localparam int IXW = (MAX_VL > 1) ? $clog2(MAX_VL) : 1;
    localparam logic [VW-1:0] MAXV = VW'(MAX_VL);

    svl_state_e state_q, state_d;

    logic [VW-1:0]             vl_q;
    logic [1:0]                last_q;
    logic                      twin_q;
    logic [2:0]                code_q;
    logic [1:0]                vec_q;
    logic [1:0][5:0]           field_q;
    logic [MAX_VL-1:0]         m9_q, m10_q, m11_q;
    logic [1:0][VW-1:0]        idx_q;
    logic [1:0]                sub_q;

    logic [1:0][MAX_VL-1:0]    op_mask;
    logic [1:0]                op_pred;
    logic [1:0]                fnd;
    logic [1:0][VW-1:0]        pos;
    logic [1:0][RW-1:0]        regn;
    logic [VW-1:0]             vl_clamp;
    logic                      last_sub;
    logic                      scalar_stop;
    svl_save_t                 sin, sout;

    assign sin         = state_in;
    assign vl_clamp    = (vl > MAXV) ? MAXV : vl;
    assign last_sub    = (sub_q == last_q);
    assign scalar_stop = (!vec_q[0] && op_pred[0]) || (!vec_q[1] && op_pred[1]);

    svl_pred_sel #(.MAX_VL(MAX_VL)) u_pred (
        .twin     (twin_q),
        .code     (code_q),
        .m9       (m9_q),
        .m10      (m10_q),
        .m11      (m11_q),
        .src_mask (op_mask[0]),
        .dst_mask (op_mask[1]),
        .src_pred (op_pred[0]),
        .dst_pred (op_pred[1])
    );

    // operand 0 is the source, operand 1 the destination
    for (genvar g = 0; g < 2; g++) begin : g_op
        svl_find_next #(.MAX_VL(MAX_VL)) u_find (
            .mask  (op_mask[g]),
            .from  (idx_q[g]),
            .lim   (vl_q),
            .found (fnd[g]),
            .pos   (pos[g])
        );
        svl_reg_map u_map (
            .field   (field_q[g]),
            .is_vec  (vec_q[g]),
            .idx     (idx_q[g]),
            .reg_num (regn[g])
        );
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SEEK;
            ST_SEEK: begin
                if (exception)   state_d = ST_IDLE;
                else if (&fnd)   state_d = ST_ISSUE;
                else             state_d = ST_FINISH;
            end
            ST_ISSUE: begin
                if (exception)      state_d = ST_IDLE;
                else if (last_sub)  state_d = scalar_stop ? ST_FINISH : ST_SEEK;
                else                state_d = ST_ISSUE;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // loop counters and captured configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vl_q    <= '0;
            last_q  <= '0;
            twin_q  <= 1'b0;
            code_q  <= '0;
            vec_q   <= '0;
            field_q <= '0;
            m9_q    <= '0;
            m10_q   <= '0;
            m11_q   <= '0;
            idx_q   <= '0;
            sub_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    vl_q       <= vl_clamp;
                    last_q     <= svlen_code;
                    twin_q     <= twin_mode;
                    code_q     <= pred_code;
                    vec_q      <= {dst_is_vec, src_is_vec};
                    field_q[0] <= src_field;
                    field_q[1] <= dst_field;
                    m9_q       <= mask_x9;
                    m10_q      <= mask_x10;
                    m11_q      <= mask_x11;
                    idx_q[0]   <= sin.src_offs;
                    idx_q[1]   <= sin.dst_offs;
                    sub_q      <= sin.src_sub;
                end
                ST_SEEK: if (!exception) begin
                    if (&fnd) begin
                        idx_q[0] <= pos[0];
                        idx_q[1] <= pos[1];
                    end else begin
                        idx_q <= '0;
                        sub_q <= '0;
                    end
                end
                ST_ISSUE: if (!exception) begin
                    if (last_sub) begin
                        sub_q <= '0;
                        if (scalar_stop) begin
                            idx_q <= '0;
                        end else begin
                            idx_q[0] <= idx_q[0] + 1'b1;
                            idx_q[1] <= idx_q[1] + 1'b1;
                        end
                    end else begin
                        sub_q <= sub_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        issue_valid   = (state_q == ST_ISSUE) && !exception;
        issue_src_reg = regn[0];
        issue_dst_reg = regn[1];
        issue_src_idx = idx_q[0];
        issue_dst_idx = idx_q[1];
        issue_sub     = sub_q;
        done          = (state_q == ST_FINISH);
        sout.rsvd     = 1'b0;
        sout.dst_sub  = sub_q;
        sout.src_sub  = sub_q;
        sout.subvl    = {1'b0, last_q} + 3'd1;
        sout.dst_offs = idx_q[1];
        sout.src_offs = idx_q[0];
        sout.vlen     = vl_q;
        sout.maxvl    = MAXV;
        state_out     = sout;
    end

    AST_SUB_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> issue_sub <= last_q);                              // R1
    AST_SUB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && $past(issue_valid) |-> issue_sub == $past(issue_sub) + 2'd1); // R1
    AST_SRC_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> op_mask[0][idx_q[0][IXW-1:0]]);                    // R2
    AST_DST_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> op_mask[1][idx_q[1][IXW-1:0]]);                    // R3
    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (idx_q[0] < vl_q) && (idx_q[1] < vl_q));           // R4
    AST_SCALAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && $past(issue_valid) && !vec_q[0] |-> $stable(issue_src_reg)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                   // R7
    AST_QUIET_AFTER_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        $past(exception) && ($past(state_q) == ST_ISSUE || $past(state_q) == ST_SEEK)
        |-> !issue_valid);                                                 // R8
endmodule

// File: tb/tb_svl_loop_seq.sv
module tb_svl_loop_seq;
    localparam int MV = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic exception = 1'b0;
    logic [5:0] vl = '0;
    logic [1:0] svlen_code = '0;
    logic twin_mode = 1'b0;
    logic [2:0] pred_code = '0;
    logic src_is_vec = 1'b0;
    logic dst_is_vec = 1'b0;
    logic [5:0] src_field = '0;
    logic [5:0] dst_field = '0;
    logic [MV-1:0] mask_x9 = '0;
    logic [MV-1:0] mask_x10 = '0;
    logic [MV-1:0] mask_x11 = '0;
    logic [31:0] state_in = '0;
    logic issue_valid;
    logic [6:0] issue_src_reg, issue_dst_reg;
    logic [5:0] issue_src_idx, issue_dst_idx;
    logic [1:0] issue_sub;
    logic done;
    logic [31:0] state_out;

    svl_loop_seq #(.MAX_VL(MV)) dut (.*);

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    int exp_n;
    int e_sr[64], e_dr[64], e_si[64], e_di[64], e_sb[64];
    int got_n;
    int g_sr[64], g_dr[64], g_si[64], g_di[64], g_sb[64];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic int regno(input int f, input bit vec, input int idx);
        int b;
        if (!vec) return f;
        b = ((f & 1) << 6) | (((f >> 1) & 31) << 1);
        return (b + idx) % 128;
    endfunction

    // expected step stream from the requirements
    task automatic build_exp(input int s0, input int d0, input int sb0);
        int ve, n, si, di, sb;
        bit [MV-1:0] sm, dm, pk;
        bit sp, dp;
        ve = (vl > MV) ? MV : int'(vl);
        n  = int'(svlen_code) + 1;
        sm = '1; dm = '1; sp = 0; dp = 0;
        if (!twin_mode) begin
            if (pred_code[2:1] != 0) begin
                pk = (pred_code[2:1] == 1) ? mask_x9 : (pred_code[2:1] == 2) ? mask_x10 : mask_x11;
                if (!pred_code[0]) pk = ~pk;
                sm = pk; dm = pk; sp = 1; dp = 1;
            end
        end else if (pred_code != 3'b100) begin
            if (pred_code[0]) begin sp = 1; sm = pred_code[2] ? ~mask_x9 : mask_x9; end
            if (pred_code[1]) begin dp = 1; dm = pred_code[2] ? ~mask_x10 : mask_x10; end
        end
        exp_n = 0; si = s0; di = d0; sb = sb0;
        forever begin
            while (si < ve && !sm[si]) si++;
            while (di < ve && !dm[di]) di++;
            if (si >= ve || di >= ve) break;
            for (int s = sb; s < n; s++) begin
                e_sr[exp_n] = regno(src_field, src_is_vec, si);
                e_dr[exp_n] = regno(dst_field, dst_is_vec, di);
                e_si[exp_n] = si; e_di[exp_n] = di; e_sb[exp_n] = s;
                exp_n++;
            end
            sb = 0;
            if ((!src_is_vec && sp) || (!dst_is_vec && dp)) break;
            si++; di++;
        end
    endtask

    task automatic run_seq(input int abort_at, output bit got_done);
        got_n = 0; got_done = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int c = 0; c < 300; c++) begin
            if (issue_valid) begin
                g_sr[got_n] = issue_src_reg; g_dr[got_n] = issue_dst_reg;
                g_si[got_n] = issue_src_idx; g_di[got_n] = issue_dst_idx;
                g_sb[got_n] = issue_sub;
                got_n++;
                if (got_n - 1 == abort_at) begin
                    exception = 1'b1;
                    @(negedge clk);
                    exception = 1'b0;
                    return;
                end
            end
            if (done) begin got_done = 1; return; end
            @(negedge clk);
        end
    endtask

    task automatic cmp_stream(input string req, input int off);
        bit ok = 1;
        int first = -1;
        if (got_n != exp_n - off) ok = 0;
        else for (int i = 0; i < got_n; i++)
            if (g_sr[i] != e_sr[i+off] || g_dr[i] != e_dr[i+off] || g_si[i] != e_si[i+off] ||
                g_di[i] != e_di[i+off] || g_sb[i] != e_sb[i+off]) begin
                ok = 0; if (first < 0) first = i;
            end
        if (first >= 0)
            chk(ok, req, "step content (src_reg)", g_sr[first], e_sr[first+off]);
        else
            chk(ok, req, "step count", got_n, exp_n - off);
    endtask

    function automatic longint word(input int so, input int dso, input int sub,
                                    input int vv, input int n);
        return (longint'(sub) << 29) | (longint'(sub) << 27) | (longint'(n) << 24) |
               (longint'(dso) << 18) | (longint'(so) << 12) | (longint'(vv) << 6) | MV;
    endfunction

    initial begin
        #(10 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit gd;
        int r, ve, k;
        longint sw;
        #23 rst_n = 1'b1;
        @(negedge clk);
        chk(issue_valid == 0 && done == 0, "R7", "reset outputs", {issue_valid, done}, 0);
        chk(state_out == 32'h0100_0000 + MV, "R9", "reset save word", state_out, 32'h0100_0000 + MV);

        // sweep: sub-vector code x mode x code x operand kinds
        r = 0;
        for (int sv = 0; sv < 4; sv++)
        for (int tw = 0; tw < 2; tw++)
        for (int pc = 0; pc < 8; pc++)
        for (int ok = 0; ok < 4; ok++) begin
            svlen_code = 2'(sv); twin_mode = tw[0]; pred_code = 3'(pc);
            src_is_vec = ok[0]; dst_is_vec = ok[1];
            vl = 6'(1 + (r % 8));
            mask_x9 = 8'(r * 73 + 29); mask_x10 = 8'(r * 151 + 90); mask_x11 = 8'(r * 53 + 200);
            src_field = 6'(r * 7 + 3); dst_field = 6'(r * 11 + 40);
            state_in = '0;
            build_exp(0, 0, 0);
            run_seq(-1, gd);
            ve = int'(vl);
            // R1 R4 R5 R6 streams under R2 (single) / R3 (twin) codes
            cmp_stream(tw ? "R3 R4 R5 R6" : "R1 R2 R5 R6", 0);
            chk(gd, "R7", "done seen", gd, 1);
            chk(state_out == word(0, 0, 0, ve, sv + 1), "R9", "save word after done",
                state_out, word(0, 0, 0, ve, sv + 1));
            r++;
        end

        // R7: length clamp and zero length
        svlen_code = 2'd1; twin_mode = 0; pred_code = 3'd0; src_is_vec = 1; dst_is_vec = 1;
        vl = 6'd20; build_exp(0, 0, 0); run_seq(-1, gd);
        chk(got_n == 16, "R7", "clamped step count", got_n, 16);
        cmp_stream("R7", 0);
        vl = 6'd0; build_exp(0, 0, 0); run_seq(-1, gd);
        chk(gd && got_n == 0, "R7", "zero length", got_n, 0);

        // R6: scalar source with single predicate stops after first group
        vl = 6'd8; svlen_code = 2'd2; pred_code = 3'd3; mask_x9 = 8'b0110_0100;
        src_is_vec = 0; dst_is_vec = 1;
        build_exp(0, 0, 0); run_seq(-1, gd);
        chk(got_n == 3 && g_si[0] == 2, "R6", "scalar stop count", got_n, 3);

        // R8, R9, R10: exception mid-group then resume
        vl = 6'd6; svlen_code = 2'd2; twin_mode = 1; pred_code = 3'd3;
        mask_x9 = 8'b0011_0110; mask_x10 = 8'b0010_1101;
        src_is_vec = 1; dst_is_vec = 1; src_field = 6'd13; dst_field = 6'd50;
        state_in = '0;
        build_exp(0, 0, 0);
        k = 4;
        run_seq(k, gd);
        sw = word(e_si[k], e_di[k], e_sb[k], 6, 3);
        chk(state_out == sw, "R9", "saved word at exception", state_out, sw);
        chk(g_sb[k] == 1, "R8", "aborted step sub", g_sb[k], 1);
        for (int q = 0; q < 3; q++) begin
            @(negedge clk);
            chk(!issue_valid && !done, "R8", "quiet after exception", issue_valid, 0);
        end
        state_in = state_out;
        run_seq(-1, gd);
        cmp_stream("R10", k);
        chk(gd, "R10", "done after resume", gd, 1);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule